// File: doc/BRIEF.md
# I2C Target with Word-Accessed Byte Files

This block is an I2C target that answers one programmable 7-bit device address. Bytes that the bus controller writes are stored in a circular 64-byte receive file. Bytes that the controller reads are taken from a separate circular 64-byte transmit file. A local CPU sees both files only as aligned 32-bit words. Byte n of either stream lives in word n/4, in the byte lane selected by n mod 4, with the lowest lane first.

SCL and SDA are brought into the system clock through two-flop synchronizers. A bit engine then detects START and STOP, matches the address, drives ACK, and shifts data bytes in and out. Software learns how much arrived from a byte-granular receive pointer. A bit-granular transmit pointer shows how far the controller has read, including progress inside a partly sent byte. Three status bits record:
- the beginning of a read,
- the end of a read,
- the end of a write.

Each status bit has its own enable and is cleared by writing 1.

Top module: `i2c_word_target`

## Requirements
- R1: After reset the receive pointer, the transmit pointer and the status register read 0, the device address reads 0x50, irq is low and SDA is released.
- R2: An address byte is the 7-bit address followed by a direction bit (0 = controller writes, 1 = controller reads). A matching address is ACKed by pulling SDA low in the ninth clock. A non-matching address is NACKed, and none of its bytes are stored.
- R3: In a write, every data byte is ACKed and stored at the receive pointer: byte n goes to receive word n>>2, bits 8*(n&3)+7 down to 8*(n&3). The receive pointer register (word address 32, bits 5:0) then increments, wrapping modulo 64.
- R4: In a read, each byte is taken from the transmit file at byte index rdPtr[8:3] and sent MSB first. A controller ACK continues with the next byte.
- R5: The transmit pointer register (word address 33, bits 8:0) increments once per transmitted data bit. Bits 8:3 hold the byte index and bits 2:0 the bit within the current byte.
- R6: Status register (word address 36) bits:
  - bit 0 is set when a read address is ACKed;
  - bit 1 is set on STOP or repeated START after a matched read;
  - bit 2 is set on STOP or repeated START after a matched write, including a write that carried only the address.

  irq is high exactly when some status bit and the matching bit of the enable register (word address 35, bits 2:0) are both 1.
- R7: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R8: The device address is programmable at word address 34, bits 6:0, and takes effect for the next address byte.
- R9: Any write to word address 32 or 33 sets that pointer to 0, whatever the data.
- R10: CPU word addresses 0 to 15 read the receive file and ignore writes. Addresses 16 to 31 read and write the transmit file. Read data appears on cpuRdata in the cycle after the request.
- R11: A controller NACK after a read byte ends the read, and the target keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line as seen on the pad |
| sdaIn | input | 1 | SDA line as seen on the pad |
| sdaOe | output | 1 | 1 = pull SDA low (open drain) |
| cpuEn | input | 1 | CPU access request |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 6 | CPU word address |
| cpuWdata | input | 32 | CPU write data |
| cpuRdata | output | 32 | CPU read data, valid the cycle after a read request |
| irq | output | 1 | Interrupt request |

## Verification
Writes are tried with random lengths from one byte up, and with a 66-byte burst. The burst separates correct modulo-64 wrapping and lane placement from a pointer that saturates or misplaces bytes. Reads run at random starting byte positions, and one read is paused mid-byte to expose the bit field of the transmit pointer. A foreign address, a changed device address and a write followed by a repeated-START read test the address match and show which event sets each status bit. CPU writes to the receive file and to the pointers use arbitrary data, so that ignored and zeroing accesses are distinguished from plain stores.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  // Strobes from the bus engine to the storage side
  typedef struct packed {
    logic       wrByte;   // a received byte is ready
    logic [7:0] wrData;
    logic       rdBit;    // one transmitted bit completed
    logic       rdStart;  // read address acknowledged
    logic       rdDone;   // matched read ended
    logic       wrDone;   // matched write ended
  } tgtStrobe_t;

  // register indices inside the register window
  localparam logic [2:0] REG_WRPTR = 3'd0;
  localparam logic [2:0] REG_RDPTR = 3'd1;
  localparam logic [2:0] REG_DEVADDR = 3'd2;
  localparam logic [2:0] REG_INTEN = 3'd3;
  localparam logic [2:0] REG_INTSTAT = 3'd4;

  // interrupt bit positions
  localparam int INT_RDSTART = 0;
  localparam int INT_RDDONE = 1;
  localparam int INT_WRDONE = 2;

endpackage

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] devAddr,
  input  logic [7:0] txByte,
  output logic       sdaOe,
  output tgtStrobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } tgtState_e;

  // ---- input synchronizers, one chain per line ----
  logic [1:0] rawIn;
  logic [1:0] syncOut;
  assign rawIn = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = syncOut[1];
  assign sdaS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;

  // ---- bit engine ----
  tgtState_e  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn, shiftOut;
  logic       isRead, inWrite, inRead, ackSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftIn  <= '0;
      shiftOut <= '0;
      isRead   <= 1'b0;
      inWrite  <= 1'b0;
      inRead   <= 1'b0;
      ackSeen  <= 1'b0;
      strb     <= '0;
    end else begin
      strb <= '0;
      if (startDet || stopDet) begin
        strb.wrDone <= inWrite;
        strb.rdDone <= inRead;
        inWrite     <= 1'b0;
        inRead      <= 1'b0;
        bitCnt      <= '0;
        state       <= startDet ? ST_ADDR : ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (shiftIn[7:1] == devAddr) begin
                state  <= ST_AACK;
                isRead <= shiftIn[0];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                state        <= ST_RDATA;
                shiftOut     <= txByte;
                inRead       <= 1'b1;
                strb.rdStart <= 1'b1;
              end else begin
                state   <= ST_WDATA;
                inWrite <= 1'b1;
              end
            end
          end
          ST_WDATA: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              strb.wrByte <= 1'b1;
              strb.wrData <= shiftIn;
              state       <= ST_WACK;
            end
          end
          ST_WACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (sclFall) begin
              shiftOut   <= {shiftOut[6:0], 1'b1};
              bitCnt     <= bitCnt + 4'd1;
              strb.rdBit <= 1'b1;
              if (bitCnt == 4'd7) state <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (sclRise) ackSeen <= !sdaS;
            if (sclFall) begin
              bitCnt <= '0;
              if (ackSeen) begin
                shiftOut <= txByte;
                state    <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sdaOe = (state == ST_AACK) || (state == ST_WACK) ||
                 ((state == ST_RDATA) && !shiftOut[7]);

  // ---- assertions ----
  a_r2_start_to_addr: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR));

  a_r6_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDone, strb.rdDone}));

  a_r11_nack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclFall && !ackSeen && !startDet && !stopDet) |=> !sdaOe);

  a_r4_bit_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdBit |-> $past(sclFall));

endmodule

// File: rtl/i2ct_data.sv
module i2ct_data
  import i2ct_pkg::*;
#(
  parameter int         FILE_BYTES = 64,
  parameter logic [6:0] DEF_ADDR   = 7'h50,
  localparam int        BYTE_AW    = $clog2(FILE_BYTES),
  localparam int        WORDS      = FILE_BYTES / 4,
  localparam int        WORD_AW    = BYTE_AW - 2,
  localparam int        RDP_W      = BYTE_AW + 3,
  localparam int        CPU_AW     = WORD_AW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgtStrobe_t        strb,
  output logic [7:0]        txByte,
  output logic [6:0]        devAddr,
  input  logic              cpuEn,
  input  logic              cpuWe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              irq
);

  logic [31:0]        rxMem [WORDS];
  logic [31:0]        txMem [WORDS];
  logic [BYTE_AW-1:0] wrPtr;
  logic [RDP_W-1:0]   rdPtr;
  logic [2:0]         intEn, intStat, setVec, w1c;

  // ---- CPU decode ----
  logic regWr, txWr, wrPtrClr, rdPtrClr;
  assign regWr    = cpuEn && cpuWe && cpuAddr[CPU_AW-1];
  assign txWr     = cpuEn && cpuWe && !cpuAddr[CPU_AW-1] && cpuAddr[CPU_AW-2];
  assign wrPtrClr = regWr && (cpuAddr[2:0] == REG_WRPTR);
  assign rdPtrClr = regWr && (cpuAddr[2:0] == REG_RDPTR);
  assign w1c      = (regWr && cpuAddr[2:0] == REG_INTSTAT) ? cpuWdata[2:0] : 3'b000;

  // ---- receive file and pointer ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) rxMem[i] <= '0;
      wrPtr <= '0;
    end else begin
      if (strb.wrByte)
        rxMem[wrPtr[BYTE_AW-1:2]][{wrPtr[1:0], 3'b000} +: 8] <= strb.wrData;
      if (wrPtrClr)         wrPtr <= '0;
      else if (strb.wrByte) wrPtr <= wrPtr + 1'b1;
    end
  end

  // ---- transmit file and bit pointer ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) txMem[i] <= '1;
      rdPtr <= '0;
    end else begin
      if (txWr) txMem[cpuAddr[WORD_AW-1:0]] <= cpuWdata;
      if (rdPtrClr)        rdPtr <= '0;
      else if (strb.rdBit) rdPtr <= rdPtr + 1'b1;
    end
  end

  logic [31:0] txWord;
  assign txWord = txMem[rdPtr[RDP_W-1:5]];
  assign txByte = txWord[{rdPtr[4:3], 3'b000} +: 8];

  // ---- control registers and interrupts ----
  assign setVec = {strb.wrDone, strb.rdDone, strb.rdStart};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devAddr <= DEF_ADDR;
      intEn   <= '0;
      intStat <= '0;
    end else begin
      if (regWr && cpuAddr[2:0] == REG_DEVADDR) devAddr <= cpuWdata[6:0];
      if (regWr && cpuAddr[2:0] == REG_INTEN)   intEn   <= cpuWdata[2:0];
      intStat <= setVec | (intStat & ~w1c);
    end
  end

  assign irq = |(intStat & intEn);

  // ---- read mux ----
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (cpuAddr[CPU_AW-1]) begin
      unique case (cpuAddr[2:0])
        REG_WRPTR:   rdMux[BYTE_AW-1:0] = wrPtr;
        REG_RDPTR:   rdMux[RDP_W-1:0]   = rdPtr;
        REG_DEVADDR: rdMux[6:0]         = devAddr;
        REG_INTEN:   rdMux[2:0]         = intEn;
        REG_INTSTAT: rdMux[2:0]         = intStat;
        default:     rdMux              = '0;
      endcase
    end else if (cpuAddr[CPU_AW-2]) begin
      rdMux = txMem[cpuAddr[WORD_AW-1:0]];
    end else begin
      rdMux = rxMem[cpuAddr[WORD_AW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cpuRdata <= '0;
    else if (cpuEn && !cpuWe) cpuRdata <= rdMux;
  end

  logic unusedBits;
  assign unusedBits = ^{cpuWdata[31:7], cpuAddr[WORD_AW-1:3]};

  // ---- assertions ----
  a_r3_wrptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte && !wrPtrClr) |=> (wrPtr == $past(wrPtr) + 1'b1));

  a_r5_rdptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdBit && !rdPtrClr) |=> (rdPtr == $past(rdPtr) + 1'b1));

  a_r9_ptr_zeroed: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtrClr || rdPtrClr) |=> ((wrPtr == '0) || (rdPtr == '0)));

  a_r6_wrdone_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStat[INT_WRDONE]) |-> $past(strb.wrDone));

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (w1c[INT_RDDONE] && !setVec[INT_RDDONE]) |=> !intStat[INT_RDDONE]);

endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2ct_pkg::*;
#(
  parameter int         FILE_BYTES  = 64,
  parameter logic [6:0] DEF_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclIn,
  input  logic                          sdaIn,
  output logic                          sdaOe,
  input  logic                          cpuEn,
  input  logic                          cpuWe,
  input  logic [$clog2(FILE_BYTES)-1:0] cpuAddr,
  input  logic [31:0]                   cpuWdata,
  output logic [31:0]                   cpuRdata,
  output logic                          irq
);

  tgtStrobe_t strb;
  logic [7:0] txByte;
  logic [6:0] devAddr;

  i2ct_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devAddr(devAddr), .txByte(txByte), .sdaOe(sdaOe), .strb(strb)
  );

  i2ct_data #(.FILE_BYTES(FILE_BYTES), .DEF_ADDR(DEF_ADDR)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .txByte(txByte), .devAddr(devAddr),
    .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .irq(irq)
  );

endmodule

// File: tb/test_i2c_word_target.sv
module test_i2c_word_target;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclCtl = 1'b1, sdaCtl = 1'b1;
  logic        sdaOe, sdaLine, irq;
  logic        cpuEn = 1'b0, cpuWe = 1'b0;
  logic [5:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0, cpuRdata;

  assign sdaLine = sdaCtl & ~sdaOe;

  i2c_word_target i_i2c_word_target (
    .clk(clk), .rstN(rstN), .sclIn(sclCtl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .irq(irq)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] rxM [64];
  logic [7:0] txM [64];
  int wrPtrM = 0, rdPtrM = 0;
  logic [7:0] wbuf [80];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic cpuWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuEn = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuEn = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic cpuRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cpuEn = 1'b1; cpuWe = 1'b0; cpuAddr = a;
    @(negedge clk);
    cpuEn = 1'b0;
    d = cpuRdata;
  endtask

  task automatic i2cBit(input logic v, output logic s);
    sdaCtl = v; waitQ();
    sclCtl = 1'b1; waitQ();
    s = sdaLine; waitQ();
    sclCtl = 1'b0; waitQ();
  endtask

  task automatic i2cStart();
    sdaCtl = 1'b1; waitQ();
    sclCtl = 1'b1; waitQ();
    sdaCtl = 1'b0; waitQ();
    sclCtl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaCtl = 1'b0; waitQ();
    sclCtl = 1'b1; waitQ();
    sdaCtl = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) i2cBit(b[i], s);
    i2cBit(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 0; i < 8; i++) begin
      i2cBit(1'b1, s);
      b = {b[6:0], s};
    end
    i2cBit(nack, s);
  endtask

  function automatic logic [31:0] rxWord(input int w);
    return {rxM[4*w+3], rxM[4*w+2], rxM[4*w+1], rxM[4*w]};
  endfunction

  // write transaction of n bytes from wbuf; updates the model
  task automatic doWrite(input logic [6:0] a, input int n, input logic expAck);
    logic ack;
    i2cStart();
    sendByte({a, 1'b0}, ack);
    check(expAck ? "R2 address ACK" : "R2 foreign address NACK", ack, expAck);
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack);
      if (expAck) begin
        check("R3 data byte ACK", ack, 1'b1);
        rxM[wrPtrM] = wbuf[i];
        wrPtrM = (wrPtrM + 1) % 64;
      end
    end
    i2cStop();
  endtask

  task automatic doRead(input int n);
    logic ack;
    logic [7:0] b;
    i2cStart();
    sendByte({7'h50, 1'b1}, ack);
    check("R2 read address ACK", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, b);
      check("R4 read byte", b, txM[rdPtrM / 8]);
      rdPtrM = (rdPtrM + 8) % 512;
    end
    i2cStop();
  endtask

  task automatic checkRxFile(input string tag);
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      cpuRd(6'(w), d);
      check(tag, d, rxWord(w));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic ack, s;
    logic [7:0] b;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) begin rxM[i] = 8'h00; txM[i] = 8'hFF; end

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    cpuRd(6'd32, d); check("R1 wrPtr reset", d, 0);
    cpuRd(6'd33, d); check("R1 rdPtr reset", d, 0);
    cpuRd(6'd34, d); check("R1 devAddr reset", d, 32'h50);
    cpuRd(6'd36, d); check("R1 status reset", d, 0);
    check("R1 irq reset", irq, 1'b0);
    check("R1 SDA released", sdaLine, 1'b1);

    cpuWr(6'd35, 32'h7);

    // R3 random write lengths
    for (int r = 0; r < 6; r++) begin
      int n;
      n = 1 + int'($urandom_range(0, 5));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      doWrite(7'h50, n, 1'b1);
      cpuRd(6'd36, d); check("R6 end-of-write status", d, 32'h4);
      check("R6 irq on write end", irq, 1'b1);
      cpuWr(6'd36, 32'h4);
      cpuRd(6'd36, d); check("R7 W1C clears", d, 0);
    end
    cpuRd(6'd32, d); check("R3 wrPtr count", d, wrPtrM);
    checkRxFile("R3 receive word");

    // R6 address-only write still flags end of write
    doWrite(7'h50, 0, 1'b1);
    cpuRd(6'd36, d); check("R6 address-only write", d, 32'h4);
    cpuWr(6'd36, 32'h0);
    cpuRd(6'd36, d); check("R7 write of 0 keeps bit", d, 32'h4);
    cpuWr(6'd36, 32'h7);

    // R2 foreign address
    for (int i = 0; i < 3; i++) wbuf[i] = 8'hA5;
    doWrite(7'h51, 3, 1'b0);
    cpuRd(6'd32, d); check("R2 foreign bytes not stored", d, wrPtrM);
    cpuRd(6'd36, d); check("R2 foreign no status", d, 0);

    // R8 programmable address
    cpuWr(6'd34, 32'hFFFF_FF2A);
    cpuRd(6'd34, d); check("R8 devAddr readback", d, 32'h2A);
    wbuf[0] = 8'h3C;
    doWrite(7'h2A, 1, 1'b1);
    doWrite(7'h50, 1, 1'b0);
    cpuWr(6'd34, 32'h50);
    cpuWr(6'd36, 32'h7);

    // R9 pointer zero, R3 wrap with 66-byte burst
    cpuWr(6'd32, 32'hFFFF_FFFF);
    wrPtrM = 0;
    cpuRd(6'd32, d); check("R9 wrPtr zeroed", d, 0);
    for (int i = 0; i < 66; i++) wbuf[i] = 8'($urandom);
    doWrite(7'h50, 66, 1'b1);
    cpuRd(6'd32, d); check("R3 wrPtr wraps", d, 2);
    checkRxFile("R3 wrapped word");
    cpuWr(6'd36, 32'h7);

    // R10 receive file ignores writes, transmit file R/W
    cpuWr(6'd0, 32'hDEAD_BEEF);
    cpuRd(6'd0, d); check("R10 rx file write ignored", d, rxWord(0));
    for (int w = 0; w < 16; w++) begin
      d = $urandom;
      cpuWr(6'(16 + w), d);
      for (int k = 0; k < 4; k++) txM[4*w+k] = d[8*k +: 8];
    end
    cpuRd(6'd21, d); check("R10 tx file readback", d, {txM[23], txM[22], txM[21], txM[20]});

    // R4 / R6 read with start status
    i2cStart();
    sendByte({7'h50, 1'b1}, ack);
    check("R2 read address ACK", ack, 1'b1);
    cpuRd(6'd36, d); check("R6 start-of-read status", d, 32'h1);
    recvByte(1'b0, b);
    check("R4 first byte MSB first", b, txM[0]);
    rdPtrM = 8;
    // R5 partial byte progress
    b = '0;
    for (int i = 0; i < 3; i++) begin i2cBit(1'b1, s); b = {b[6:0], s}; end
    cpuRd(6'd33, d); check("R5 mid-byte bit position", d, 11);
    for (int i = 0; i < 5; i++) begin i2cBit(1'b1, s); b = {b[6:0], s}; end
    check("R4 second byte", b, txM[1]);
    i2cBit(1'b1, s);                    // controller NACK
    rdPtrM = 16;
    i2cBit(1'b1, s);
    check("R11 SDA released after NACK", s, 1'b1);
    i2cBit(1'b1, s);
    check("R11 still released", s, 1'b1);
    i2cStop();
    cpuRd(6'd33, d); check("R5 bit pointer after read", d, rdPtrM);
    cpuRd(6'd36, d); check("R6 end-of-read status", d, 32'h3);
    cpuWr(6'd36, 32'h7);

    // R4 random reads
    for (int r = 0; r < 4; r++) begin
      doRead(1 + int'($urandom_range(0, 4)));
      cpuRd(6'd33, d); check("R5 bit pointer", d, rdPtrM);
      cpuWr(6'd36, 32'h7);
    end

    // R6 repeated START after write flags end of write
    i2cStart();
    sendByte({7'h50, 1'b0}, ack);
    sendByte(8'h77, ack);
    check("R3 register byte ACK", ack, 1'b1);
    rxM[wrPtrM] = 8'h77; wrPtrM = (wrPtrM + 1) % 64;
    i2cStart();
    cpuRd(6'd36, d); check("R6 repeated START ends write", d, 32'h4);
    sendByte({7'h50, 1'b1}, ack);
    recvByte(1'b1, b);
    check("R4 byte after repeated START", b, txM[rdPtrM / 8]);
    rdPtrM = (rdPtrM + 8) % 512;
    i2cStop();
    cpuRd(6'd36, d); check("R6 all three status bits", d, 32'h7);

    // R6 enable gating
    check("R6 irq enabled", irq, 1'b1);
    cpuWr(6'd35, 32'h0);
    @(negedge clk);
    check("R6 irq masked", irq, 1'b0);

    // R9 read pointer zeroed
    cpuWr(6'd33, 32'h1234_5678);
    cpuRd(6'd33, d); check("R9 rdPtr zeroed", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule